// File: doc/BRIEF.md
# Endian-Aware Bus Width Adapter

This block sits between an internal requester and an external memory data bus. The bus can be 8, 16 or 32 bits wide, and the width is chosen per access. The block takes one request of byte, word, long, quad or 32-byte line size and turns it into as many bus cycles as that size needs on that width. It steps the cycle address by the bus width. It places each byte on the right bus lane for the byte order chosen at power-on. For reads it assembles the item into a right-justified 64-bit word. Line transfers start at the requested data and wrap inside their aligned 32-byte block. While a sequence runs, the bus is held and refresh is kept off.

Requests use a valid/ready handshake. `req_ready` is low from the cycle after acceptance until the last bus cycle is acknowledged, so a requester with a pending request simply holds it. Each bus cycle holds its address, strobes and write data until the external `bus_ack` is sampled high, so the memory side applies back-pressure one cycle at a time. Read results and line beats are strobes with no back-pressure: the requester must take them in the cycle they are flagged.

Top module: `bus_width_adapter`

## Requirements
- R1: The byte order is captured from `endian_pin` in every clock cycle while `rst_n` is low (0 = most significant byte at the lowest address, 1 = least significant byte at the lowest address). After reset it holds, and later changes on the pin have no effect.
- R2: A non-line request of S bytes (size code 0/1/2/3 = 1/2/4/8 bytes) on a bus of W bytes (width code 0/1/2 = 1/2/4 bytes) makes max(1, S/W) bus cycles. Cycle k uses the address request + k·min(S, W).
- R3: Bus lane L is data bits 8L+7..8L. A byte whose address offset within the W-byte bus word is o travels on lane o in little-endian mode and on lane W−1−o in big-endian mode. `bus_be` marks exactly the lanes that carry bytes of the request.
- R4: A read returns its item right-justified in `rd_data`: value byte v sits at bits 8v+7..8v. The byte at request address + i is value byte i (little-endian) or S−1−i (big-endian). `rd_valid` pulses for exactly one cycle, in the cycle after the last acknowledged bus cycle.
- R5: A write takes its item right-justified from `req_wdata`, using the same byte-to-address rule as R4. Only the addressed bytes are strobed.
- R6: A line request (size code 4) makes 32/W cycles. The first cycle is at the requested address, and the low five address bits then advance by W and wrap modulo 32. Each acknowledged cycle pulses `beat_valid`: a read beat returns the raw bus word on `beat_data`, and a write beat drives `beat_wdata` onto the bus.
- R7: From the cycle after acceptance until the final acknowledge, `bus_hold` is high and `refresh_ok` is low. When idle, `refresh_ok` follows `refresh_req`.
- R8: A quad request (size code 3) is carried out only when `req_dma` is set. Otherwise `req_err` pulses and no bus cycle occurs.
- R9: A request that is misaligned is refused: `req_err` pulses in the cycle after acceptance, and no bus cycle or read strobe follows. Misaligned means the address is not a multiple of S for non-line sizes, or not a multiple of W for a line. Size codes above 4 and width code 3 are refused the same way.
- R10: `req_ready` is low whenever `bus_req` is high. While `bus_req` is high and `bus_ack` is low, the bus address and strobes are unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| endian_pin | input | 1 | Byte-order strap sampled during reset (1 = little-endian) |
| bus_wsel | input | 2 | Bus width code of the addressed region (0 = 8, 1 = 16, 2 = 32 bits) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | Request is a write |
| req_size | input | 3 | Size code (0 byte, 1 word, 2 long, 3 quad, 4 line) |
| req_dma | input | 1 | Request comes from a DMA source |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 64 | Write item, right-justified |
| req_err | output | 1 | One-cycle pulse: request refused |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a finished read |
| rd_data | output | 64 | Assembled read item, right-justified |
| beat_valid | output | 1 | Line beat strobe (one per acknowledged line cycle) |
| beat_data | output | 32 | Raw bus word of a line read beat |
| beat_wdata | input | 32 | Bus word to drive for the current line write beat |
| bus_req | output | 1 | Bus cycle active |
| bus_hold | output | 1 | Bus kept by this block |
| bus_addr | output | ADDR_W | Byte address of the current bus cycle |
| bus_we | output | 1 | Current bus cycle writes |
| bus_be | output | 4 | Byte-lane strobes |
| bus_wdata | output | 32 | Write lanes |
| bus_rdata | input | 32 | Read lanes |
| bus_ack | input | 1 | Memory ready: current cycle completes at this edge |
| refresh_req | input | 1 | Refresh request from the refresh generator |
| refresh_ok | output | 1 | Refresh allowed |

## Verification
The bench builds the block with the default 32-bit address width. Bus width and byte order are inputs, so one build reaches all three widths under both byte orders. It also reaches every split count from one cycle up to the 32-cycle line on an 8-bit bus, and wrap points inside the 32-byte block for each width. Acknowledge delays of zero, one and two cycles hold each bus cycle in its wait state for different lengths. A memory model in the bench checks read assembly, write placement and untouched neighbouring bytes.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int LANES      = 4;
  localparam int ITEM_BYTES = 8;
  localparam int LINE_LG    = 5;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_WORD = 3'd1,
    SZ_LONG = 3'd2,
    SZ_QUAD = 3'd3,
    SZ_LINE = 3'd4
  } size_e;

  function automatic logic [2:0] size_log2(input logic [2:0] code);
    return (code == SZ_LINE) ? 3'(LINE_LG) : code;
  endfunction
endpackage

// File: rtl/bwa_req_check.sv
module bwa_req_check
  import bwa_pkg::*;
(
  input  logic [2:0] size,
  input  logic [1:0] wsel,
  input  logic [4:0] addr_lo,
  input  logic       dma,
  output logic       legal,
  output logic [2:0] lg_s,
  output logic [1:0] lg_w
);
  logic [2:0] lg_align;
  logic [4:0] mask;

  always_comb begin
    lg_s     = size_log2(size);
    lg_w     = wsel;
    // line: aligned to bus width; others: natural alignment
    lg_align = (size == SZ_LINE) ? {1'b0, wsel} : size;
    mask     = 5'((6'd1 << lg_align) - 6'd1);
    legal    = (wsel != 2'd3) && (size <= 3'd4) &&
               ((size != SZ_QUAD) || dma) &&
               ((addr_lo & mask) == 5'd0);
  end
endmodule

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]          base,
  input  logic [2:0]                 lg_s,
  input  logic [1:0]                 lg_w,
  input  logic [1:0]                 lg_b,
  input  logic [4:0]                 idx,
  input  logic                       le,
  input  logic                       line,
  output logic [ADDR_W-1:0]          cyc_addr,
  output logic [LANES-1:0]           lane_en,
  output logic [LANES-1:0][2:0]      lane_vidx
);
  logic [5:0] step;
  logic [4:0] wrap_lo;
  logic [2:0] wbytes;
  logic [2:0] bbytes;
  logic [1:0] cs;
  logic [5:0] s_last;
  logic [2:0] off;
  logic [5:0] pos;

  always_comb begin
    step     = 6'(idx) << lg_b;
    wrap_lo  = base[4:0] + 5'(step);
    cyc_addr = line ? {base[ADDR_W-1:5], wrap_lo} : base + ADDR_W'(step);
    wbytes   = 3'd1 << lg_w;
    bbytes   = 3'd1 << lg_b;
    cs       = cyc_addr[1:0] & 2'(wbytes - 3'd1);
    s_last   = 6'((7'd1 << lg_s) - 7'd1);
    lane_en   = '0;
    lane_vidx = '0;
    off       = '0;
    pos       = '0;
    for (int l = 0; l < LANES; l++) begin
      if (3'(l) < wbytes) begin
        // address offset carried by this lane
        off = le ? 3'(l) : 3'(wbytes - 3'd1 - 3'(l));
        pos = step + 6'(off) - 6'(cs);
        lane_en[l]   = line || ((off >= {1'b0, cs}) && (off < {1'b0, cs} + bbytes));
        lane_vidx[l] = le ? pos[2:0] : 3'(s_last - pos);
      end
    end
  end
endmodule

// File: rtl/bwa_rd_merge.sv
module bwa_rd_merge
  import bwa_pkg::*;
(
  input  logic [ITEM_BYTES*8-1:0]   acc,
  input  logic [LANES*8-1:0]        rdata,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES-1:0][2:0]     lane_vidx,
  output logic [ITEM_BYTES*8-1:0]   merged
);
  for (genvar b = 0; b < ITEM_BYTES; b++) begin : g_byte
    logic [7:0] val;
    always_comb begin
      val = acc[8*b +: 8];
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l] && (lane_vidx[l] == 3'(b))) val = rdata[8*l +: 8];
      end
    end
    assign merged[8*b +: 8] = val;
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    endian_pin,
  input  logic [1:0]              bus_wsel,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [2:0]              req_size,
  input  logic                    req_dma,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [63:0]             req_wdata,
  output logic                    req_err,
  output logic                    rd_valid,
  output logic [63:0]             rd_data,
  output logic                    beat_valid,
  output logic [31:0]             beat_data,
  input  logic [31:0]             beat_wdata,
  output logic                    bus_req,
  output logic                    bus_hold,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_we,
  output logic [3:0]              bus_be,
  output logic [31:0]             bus_wdata,
  input  logic [31:0]             bus_rdata,
  input  logic                    bus_ack,
  input  logic                    refresh_req,
  output logic                    refresh_ok
);
  localparam int ITEM_W = ITEM_BYTES * 8;

  logic                  le_q;
  logic                  busy;
  logic [ADDR_W-1:0]     base_q;
  logic [2:0]            lg_s_q;
  logic [1:0]            lg_w_q;
  logic                  we_q;
  logic                  line_q;
  logic [ITEM_W-1:0]     wdata_q;
  logic [4:0]            idx;
  logic [ITEM_W-1:0]     acc;
  logic                  rd_valid_q;
  logic                  err_q;

  logic                  legal;
  logic [2:0]            lg_s;
  logic [1:0]            lg_w;
  logic [1:0]            lg_b;
  logic [4:0]            last_idx;
  logic [LANES-1:0]      lane_en;
  logic [LANES-1:0][2:0] lane_vidx;
  logic [ITEM_W-1:0]     merged;

  bwa_req_check u_check (
    .size    (req_size),
    .wsel    (bus_wsel),
    .addr_lo (req_addr[4:0]),
    .dma     (req_dma),
    .legal   (legal),
    .lg_s    (lg_s),
    .lg_w    (lg_w)
  );

  assign lg_b     = (lg_s_q < {1'b0, lg_w_q}) ? lg_s_q[1:0] : lg_w_q;
  assign last_idx = 5'((6'd1 << (lg_s_q - {1'b0, lg_b})) - 6'd1);

  bwa_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .base      (base_q),
    .lg_s      (lg_s_q),
    .lg_w      (lg_w_q),
    .lg_b      (lg_b),
    .idx       (idx),
    .le        (le_q),
    .line      (line_q),
    .cyc_addr  (bus_addr),
    .lane_en   (lane_en),
    .lane_vidx (lane_vidx)
  );

  bwa_rd_merge u_merge (
    .acc       (acc),
    .rdata     (bus_rdata),
    .lane_en   (lane_en),
    .lane_vidx (lane_vidx),
    .merged    (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_q       <= endian_pin;
      busy       <= 1'b0;
      base_q     <= '0;
      lg_s_q     <= '0;
      lg_w_q     <= '0;
      we_q       <= 1'b0;
      line_q     <= 1'b0;
      wdata_q    <= '0;
      idx        <= '0;
      acc        <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (legal) begin
            busy    <= 1'b1;
            base_q  <= req_addr;
            lg_s_q  <= lg_s;
            lg_w_q  <= lg_w;
            we_q    <= req_write;
            line_q  <= (req_size == SZ_LINE);
            wdata_q <= req_wdata;
            idx     <= '0;
            acc     <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (bus_ack) begin
        if (!we_q && !line_q) acc <= merged;
        if (idx == last_idx) begin
          busy       <= 1'b0;
          rd_valid_q <= !we_q && !line_q;
        end else begin
          idx <= idx + 5'd1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    assign bus_wdata[8*l +: 8] = !lane_en[l] ? 8'h00 :
                                 line_q ? beat_wdata[8*l +: 8] :
                                 wdata_q[{lane_vidx[l], 3'b000} +: 8];
  end

  assign req_ready  = !busy;
  assign req_err    = err_q;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = acc;
  assign beat_valid = busy && bus_ack && line_q;
  assign beat_data  = bus_rdata;
  assign bus_req    = busy;
  assign bus_hold   = busy;
  assign bus_we     = we_q;
  assign bus_be     = lane_en;
  assign refresh_ok = refresh_req && !busy;
endmodule

// File: rtl/bwa_checks.sv
module bwa_checks #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_size,
  input logic              req_dma,
  input logic              req_err,
  input logic              rd_valid,
  input logic              beat_valid,
  input logic              bus_req,
  input logic              bus_hold,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_ack,
  input logic              refresh_ok
);
  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  p_wait_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)));

  p_hold_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_hold && !refresh_ok));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!bus_req && !rd_valid));

  p_quad_needs_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 3'd3 && !req_dma) |=> req_err);

  p_rd_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && bus_ack));

  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_beat_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (bus_req && bus_ack));

  p_lanes_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != 4'b0000));
endmodule

bind bus_width_adapter bwa_checks #(.ADDR_W(ADDR_W)) u_bwa_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_dma    (req_dma),
  .req_err    (req_err),
  .rd_valid   (rd_valid),
  .beat_valid (beat_valid),
  .bus_req    (bus_req),
  .bus_hold   (bus_hold),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_ack    (bus_ack),
  .refresh_ok (refresh_ok)
);

// File: tb/bus_width_adapter_test.sv
`timescale 1ns/1ps
module bus_width_adapter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        endian_pin = 1'b0;
  logic [1:0]  bus_wsel = 2'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_size = 3'd0;
  logic        req_dma = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_err;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        beat_valid;
  logic [31:0] beat_data;
  logic [31:0] beat_wdata;
  logic        bus_req;
  logic        bus_hold;
  logic [31:0] bus_addr;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        refresh_req = 1'b1;
  logic        refresh_ok;

  always #4 clk = ~clk;

  bus_width_adapter uut (.*);

  typedef struct packed {
    logic        le;
    logic [1:0]  wsel;
    logic [2:0]  size;
    logic        we;
    logic        dma;
    logic [7:0]  addr;
    logic [63:0] wdata;
    logic        err;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 3'd2, 1'b0, 1'b0, 8'h08, 64'h0, 1'b0},
    '{1'b1, 2'd2, 3'd2, 1'b0, 1'b0, 8'h08, 64'h0, 1'b0},
    '{1'b0, 2'd0, 3'd2, 1'b0, 1'b0, 8'h0C, 64'h0, 1'b0},
    '{1'b1, 2'd1, 3'd2, 1'b0, 1'b0, 8'h10, 64'h0, 1'b0},
    '{1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 8'h13, 64'h0, 1'b0},
    '{1'b1, 2'd2, 3'd1, 1'b0, 1'b0, 8'h16, 64'h0, 1'b0},
    '{1'b0, 2'd1, 3'd3, 1'b0, 1'b1, 8'h18, 64'h0, 1'b0},
    '{1'b1, 2'd2, 3'd3, 1'b0, 1'b0, 8'h18, 64'h0, 1'b1},
    '{1'b0, 2'd2, 3'd1, 1'b0, 1'b0, 8'h15, 64'h0, 1'b1},
    '{1'b1, 2'd0, 3'd2, 1'b1, 1'b0, 8'h20, 64'h11223344, 1'b0},
    '{1'b0, 2'd1, 3'd2, 1'b1, 1'b0, 8'h24, 64'hAABBCCDD, 1'b0},
    '{1'b0, 2'd2, 3'd0, 1'b1, 1'b0, 8'h29, 64'h77, 1'b0},
    '{1'b1, 2'd2, 3'd4, 1'b0, 1'b0, 8'h2C, 64'h0, 1'b0},
    '{1'b0, 2'd0, 3'd4, 1'b0, 1'b0, 8'h05, 64'h0, 1'b0},
    '{1'b1, 2'd1, 3'd4, 1'b1, 1'b0, 8'h06, 64'h0, 1'b0},
    '{1'b1, 2'd3, 3'd0, 1'b0, 1'b0, 8'h00, 64'h0, 1'b1},
    '{1'b0, 2'd2, 3'd4, 1'b0, 1'b0, 8'h0A, 64'h0, 1'b1},
    '{1'b0, 2'd2, 3'd3, 1'b1, 1'b1, 8'h30, 64'h0102030405060708, 1'b0},
    '{1'b0, 2'd2, 3'd5, 1'b0, 1'b0, 8'h00, 64'h0, 1'b1},
    '{1'b1, 2'd0, 3'd3, 1'b0, 1'b1, 8'h08, 64'h0, 1'b0}
  };

  int ncmp = 0, nbad = 0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic [7:0] log_addr [64];
  logic [31:0] beat_log [64];
  int ncyc, nbeat, bk, wcnt, nrd, nerr, rdy_bad = 0, ref_bad = 0;
  int cur_w = 4, cur_delay = 0;
  logic cur_le = 1'b0;
  logic [63:0] rd_cap;

  function automatic logic [7:0] pat(input int a);
    return 8'((a & 63) * 37 + 11);
  endfunction

  function automatic logic [7:0] beat_byte(input int k, input int l);
    return 8'(128 + k * 4 + l);
  endfunction

  function automatic int lane_off(input int l, input int w, input logic le);
    return le ? l : (w - 1 - l);
  endfunction

  function automatic logic [31:0] model_word(input int ca, input int w, input logic le);
    logic [31:0] r = '0;
    int b = ca & ~(w - 1);
    for (int l = 0; l < w; l++) r[8*l +: 8] = mem[(b + lane_off(l, w, le)) & 63];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory responder: ack after cur_delay wait cycles
  initial begin
    bus_ack = 1'b0; bus_rdata = '0; beat_wdata = '0;
    forever begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) beat_wdata[8*l +: 8] = beat_byte(bk, l);
      if (bus_req && wcnt >= cur_delay) begin
        bus_ack = 1'b1;
        bus_rdata = model_word(int'(bus_addr[7:0]), cur_w, cur_le);
        #1;
        if (bus_we) begin
          for (int l = 0; l < cur_w; l++)
            if (bus_be[l]) mem[((int'(bus_addr[7:0]) & ~(cur_w - 1)) + lane_off(l, cur_w, cur_le)) & 63] = bus_wdata[8*l +: 8];
        end
        if (ncyc < 64) log_addr[ncyc] = bus_addr[7:0];
        ncyc++;
        if (beat_valid) begin
          if (nbeat < 64) beat_log[nbeat] = beat_data;
          nbeat++; bk++;
        end
        wcnt = 0;
      end else begin
        bus_ack = 1'b0; bus_rdata = '0;
        wcnt = bus_req ? wcnt + 1 : 0;
      end
    end
  end

  // monitor, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rd_valid) begin nrd++; rd_cap = rd_data; end
      if (req_err) nerr++;
      if (bus_req && req_ready) rdy_bad++;
      if (bus_req && (refresh_ok || !bus_hold)) ref_bad++;
    end
  end

  task automatic do_reset(input logic le);
    rst_n = 1'b0; endian_pin = le; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; cur_le = le;
  endtask

  task automatic run_vec(input vec_t v, input bit rst, input int delay);
    int s, w, b, n;
    bit line;
    logic [7:0] ea;
    logic [63:0] ev;
    bit ok;
    if (rst) do_reset(v.le);
    for (int i = 0; i < 64; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end
    ncyc = 0; nbeat = 0; bk = 0; nrd = 0; nerr = 0; wcnt = 0; cur_delay = delay;
    w = 1 << v.wsel; cur_w = (v.wsel == 2'd3) ? 4 : w;
    line = (v.size == 3'd4);
    s = line ? 32 : (1 << v.size);
    b = (s < w) ? s : w;
    n = v.err ? 0 : (line ? 32 / w : ((s > w) ? s / w : 1));
    @(negedge clk);
    bus_wsel = v.wsel; req_size = v.size; req_write = v.we; req_dma = v.dma;
    req_addr = {24'h0, v.addr}; req_wdata = v.wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int g = 0; g < 300 && bus_req; g++) @(negedge clk);
    repeat (2) @(negedge clk);
    // R8 R9: refusal flag
    check(nerr == (v.err ? 1 : 0), (v.size == 3'd3) ? "R8 quad refusal" : "R9 refusal flag", 64'(nerr), 64'(v.err));
    // R2 R6: cycle count
    check(ncyc == n, line ? "R6 line cycle count" : "R2 cycle count", 64'(ncyc), 64'(n));
    ok = 1'b1; ea = '0;
    for (int k = 0; k < n && k < 64; k++) begin
      ea = line ? {v.addr[7:5], 5'(int'(v.addr[4:0]) + k * w)} : 8'(int'(v.addr) + k * b);
      if (ok && log_addr[k] != ea) begin ok = 1'b0; check(1'b0, line ? "R6 wrap address" : "R2 cycle address", 64'(log_addr[k]), 64'(ea)); end
    end
    if (ok) check(1'b1, "R2 R6 addresses", 0, 0);
    if (!v.we && !line && !v.err) begin
      ev = '0;
      for (int i = 0; i < s; i++) ev[8*(cur_le ? i : s - 1 - i) +: 8] = pat(int'(v.addr) + i);
      check(nrd == 1 && rd_cap == ev, "R3 R4 read assembly", rd_cap, ev);
    end else begin
      check(nrd == 0, "R4 no read strobe", 64'(nrd), 0);
    end
    if (line && !v.err) begin
      check(nbeat == n, "R6 beat count", 64'(nbeat), 64'(n));
      if (!v.we) begin
        ok = 1'b1;
        for (int k = 0; k < n; k++) begin
          ea = {v.addr[7:5], 5'(int'(v.addr[4:0]) + k * w)};
          if (ok && beat_log[k] != model_word(int'(ea), w, cur_le)) begin
            ok = 1'b0; check(1'b0, "R6 beat data", 64'(beat_log[k]), 64'(model_word(int'(ea), w, cur_le)));
          end
        end
        if (ok) check(1'b1, "R6 beat data", 0, 0);
      end
    end
    if (v.we && !v.err) begin
      if (line) begin
        for (int k = 0; k < n; k++) begin
          ea = {v.addr[7:5], 5'(int'(v.addr[4:0]) + k * w)};
          for (int l = 0; l < w; l++) exp_mem[((int'(ea) & ~(w - 1)) + lane_off(l, w, cur_le)) & 63] = beat_byte(k, l);
        end
      end else begin
        for (int i = 0; i < s; i++) exp_mem[(int'(v.addr) + i) & 63] = v.wdata[8*(cur_le ? i : s - 1 - i) +: 8];
      end
    end
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (ok && mem[i] != exp_mem[i]) begin
        ok = 1'b0; check(1'b0, line ? "R6 line write memory" : "R3 R5 write memory", 64'(mem[i]), 64'(exp_mem[i]));
      end
    end
    if (ok) check(1'b1, "R5 memory image", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++; ncmp++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    vec_t hv;
    do_reset(1'b0);
    #2;
    // reset state (R10, R7)
    check(req_ready == 1'b1 && bus_req == 1'b0, "R10 idle after reset", {req_ready, bus_req}, 2'b10);
    check(rd_valid == 1'b0 && req_err == 1'b0 && beat_valid == 1'b0, "R4 strobes quiet after reset", {rd_valid, req_err, beat_valid}, 0);
    check(bus_hold == 1'b0 && refresh_ok == 1'b1, "R7 refresh allowed when idle", {bus_hold, refresh_ok}, 2'b01);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b1, i % 3);
    // R1: strap change after reset must not alter byte order
    do_reset(1'b0);
    endian_pin = 1'b1;
    hv = '{1'b0, 2'd2, 3'd2, 1'b0, 1'b0, 8'h04, 64'h0, 1'b0};
    run_vec(hv, 1'b0, 1);
    do_reset(1'b1);
    endian_pin = 1'b0;
    hv = '{1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 8'h02, 64'h0, 1'b0};
    run_vec(hv, 1'b0, 0);
    // back-to-back with a wait-heavy line read (R10, R7)
    hv = '{1'b1, 2'd0, 3'd4, 1'b0, 1'b0, 8'h1F, 64'h0, 1'b0};
    run_vec(hv, 1'b0, 2);
    #2;
    check(refresh_ok == 1'b1, "R7 refresh released after sequence", 64'(refresh_ok), 1);
    check(rdy_bad == 0, "R10 ready low while busy", 64'(rdy_bad), 0);
    check(ref_bad == 0, "R7 hold and refresh lockout", 64'(ref_bad), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule